// File: doc/BRIEF.md
# Way-Predicted Set-Associative Tag Lookup

This block is the tag-lookup stage of an N-way set-associative cache that guesses, for every set, which way will hit. When a request arrives, the block compares only the guessed way of the indexed set. If that way holds a valid entry with the same tag, the result is a hit that costs one cycle, the same as a direct-mapped probe. If the guess is wrong, the block holds off new requests for one cycle and compares every other way of the set. That second step ends in either a slower hit or a miss, which the surrounding cache then sends on to the next memory level.

Each response reports the outcome, the way that matched and whether the slow path was taken. The guessed way is learned from use. A slow hit moves the guess to the way that matched. A fill moves the guess to the way that was written. A miss leaves the guess unchanged. The fill port writes one entry of the tag array and its valid bit. The surrounding cache chooses which way to fill. The data array is not part of this block. When a fill and a slow-path hit update the same set on the same edge, the fill sets the guess. A fill in the same cycle as a second-step compare does not affect that compare.

Top module: `waypred_lookup`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0. Every entry is invalid, so any lookup misses. Every set's guessed way is way 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. If the guessed way of the indexed set holds a valid entry with an equal tag, `rsp_valid` is 1 in the cycle after that edge, with `rsp_hit`=1, `rsp_slow`=0 and `rsp_way` equal to the guessed way.
- R3: A way matches only when its valid bit is 1 and its stored tag equals the request tag. An entry that is filled with `fill_vld`=0 never matches, even when its tag is equal.
- R4: If the guessed way does not match but another way of the set does, `req_ready` is 0 for exactly one cycle. The response then arrives two cycles after acceptance, with `rsp_hit`=1, `rsp_slow`=1 and `rsp_way` equal to the matching way.
- R5: If no way of the set matches, the response arrives two cycles after acceptance, with `rsp_hit`=0, `rsp_slow`=1 and `rsp_way`=0.
- R6: After a slow-path hit, the guessed way of that set becomes the matching way, so the next lookup of the same tag takes the fast path.
- R7: A fill with `fill_en`=1 writes `fill_tag` and `fill_vld` into the entry at (`fill_set`, `fill_way`). It also sets that set's guessed way to `fill_way`.
- R8: A miss does not change the guessed way of the set.
- R9: Each set has its own guessed way. Fills and lookups in one set do not change the guess in another set.
- R10: While `req_ready` is 0, `req_valid` is ignored. No response is produced for it and no guessed way changes because of it.
- R11: Each accepted request produces exactly one single-cycle pulse of `rsp_valid`. Responses come in the same order as the requests were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_set | input | IDX_W | Set index of the request |
| req_tag | input | TAG_W | Tag of the request |
| req_ready | output | 1 | Block can accept a request (0 during the second compare step) |
| fill_en | input | 1 | Write one tag entry |
| fill_set | input | IDX_W | Set index of the entry to write |
| fill_way | input | WAY_W | Way of the entry to write |
| fill_tag | input | TAG_W | Tag to store |
| fill_vld | input | 1 | Valid bit to store |
| rsp_valid | output | 1 | Lookup result present for one cycle |
| rsp_hit | output | 1 | 1 on a hit, 0 on a miss |
| rsp_way | output | WAY_W | Matching way on a hit, 0 on a miss |
| rsp_slow | output | 1 | 1 when the result needed the second compare step |

## Verification
A fast hit is due in the cycle after the accepting edge. A slow hit or a miss is due one cycle later, and `req_ready` is low in the cycle between. The driver records the cycle count at acceptance together with the expected outcome. The monitor samples on falling edges and compares the elapsed cycles to 1 or 2, chosen by the expected path, so a response that is late or early fails even when its contents are right. The effects of the guessed way (R6, R8, R9, R10) are observed through the fast/slow flag and the latency of later lookups.

// File: rtl/waypred_lookup.sv
module waypred_lookup #(
  parameter int WAYS  = 8,
  parameter int SETS  = 16,
  parameter int TAG_W = 12,
  localparam int WAY_W = $clog2(WAYS),
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_set,
  input  logic [TAG_W-1:0] req_tag,
  output logic             req_ready,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             fill_vld,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [WAY_W-1:0] rsp_way,
  output logic             rsp_slow
);

  logic [TAG_W-1:0] tag_q  [SETS][WAYS];
  logic [WAYS-1:0]  vld_q  [SETS];
  logic [WAY_W-1:0] pred_q [SETS];

  logic             busy_q;
  logic [IDX_W-1:0] set_q;
  logic [TAG_W-1:0] tag_r;
  logic [WAY_W-1:0] skip_q;

  logic [WAY_W-1:0] guess;
  logic             fast_hit;
  logic             accept;
  logic             scan_hit;
  logic [WAY_W-1:0] scan_way;

  assign req_ready = !busy_q;
  assign accept    = req_valid && !busy_q;
  assign guess     = pred_q[req_set];
  assign fast_hit  = vld_q[req_set][guess] && (tag_q[req_set][guess] == req_tag);

  always_comb begin
    scan_hit = 1'b0;
    scan_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!scan_hit && (WAY_W'(w) != skip_q) && vld_q[set_q][w] &&
          (tag_q[set_q][w] == tag_r)) begin
        scan_hit = 1'b1;
        scan_way = WAY_W'(w);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_set][fill_way] <= fill_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      set_q     <= '0;
      tag_r     <= '0;
      skip_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_way   <= '0;
      rsp_slow  <= 1'b0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        pred_q[s] <= '0;
      end
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        if (fast_hit) begin
          rsp_valid <= 1'b1;
          rsp_hit   <= 1'b1;
          rsp_way   <= guess;
          rsp_slow  <= 1'b0;
        end else begin
          busy_q <= 1'b1;
          set_q  <= req_set;
          tag_r  <= req_tag;
          skip_q <= guess;
        end
      end
      if (busy_q) begin
        busy_q    <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_hit   <= scan_hit;
        rsp_way   <= scan_hit ? scan_way : '0;
        rsp_slow  <= 1'b1;
        if (scan_hit) pred_q[set_q] <= scan_way;
      end
      if (fill_en) begin
        vld_q[fill_set][fill_way] <= fill_vld;
        pred_q[fill_set]          <= fill_way;
      end
    end
  end

endmodule

module waypred_lookup_chk #(
  parameter int WAY_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [WAY_W-1:0] rsp_way,
  input logic             rsp_slow
);

  // R4
  busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> req_ready);

  // R4
  slow_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_slow) |-> $past(!req_ready));

  // R2
  fast_is_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_slow) |-> rsp_hit);

  // R5
  miss_is_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_slow && rsp_way == '0));

  // R11
  rsp_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(req_valid && req_ready) || $past(!req_ready)));

  // R10
  busy_starts_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_ready) |-> $past(req_valid));

endmodule

bind waypred_lookup waypred_lookup_chk #(.WAY_W(WAY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_slow(rsp_slow)
);

// File: tb/waypred_lookup_bench.sv
module waypred_lookup_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WAYS  = 8;
  localparam int SETS  = 16;
  localparam int TAG_W = 12;
  localparam int WAY_W = $clog2(WAYS);
  localparam int IDX_W = $clog2(SETS);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic [IDX_W-1:0] req_set = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic             req_ready;
  logic             fill_en = 1'b0;
  logic [IDX_W-1:0] fill_set = '0;
  logic [WAY_W-1:0] fill_way = '0;
  logic [TAG_W-1:0] fill_tag = '0;
  logic             fill_vld = 1'b0;
  logic             rsp_valid;
  logic             rsp_hit;
  logic [WAY_W-1:0] rsp_way;
  logic             rsp_slow;

  waypred_lookup #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_waypred_lookup (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_set(req_set), .req_tag(req_tag), .req_ready(req_ready),
    .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way),
    .fill_tag(fill_tag), .fill_vld(fill_vld),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_slow(rsp_slow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic             hit;
    logic [WAY_W-1:0] way;
    logic             slow;
    int               acc;
    string            rq;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R11: unexpected response hit=%0b way=%0d slow=%0b, expected none",
                 rsp_hit, rsp_way, rsp_slow);
      end else begin
        exp_t e;
        int lat;
        e = exp_q.pop_front();
        lat = cyc - e.acc;
        if (rsp_hit !== e.hit || rsp_way !== e.way || rsp_slow !== e.slow ||
            lat != (e.slow ? 2 : 1)) begin
          fails++;
          $display("FAIL %s: got hit=%0b way=%0d slow=%0b lat=%0d, expected hit=%0b way=%0d slow=%0b lat=%0d",
                   e.rq, rsp_hit, rsp_way, rsp_slow, lat, e.hit, e.way, e.slow, e.slow ? 2 : 1);
        end
      end
    end
  end

  task automatic lookup(input int s, input int t, input bit eh, input int ew,
                        input bit es, input string rq);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_set   = IDX_W'(s);
    req_tag   = TAG_W'(t);
    e.hit = eh; e.way = WAY_W'(ew); e.slow = es; e.acc = cyc; e.rq = rq;
    exp_q.push_back(e);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic fill(input int s, input int w, input int t, input bit v);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    fill_en  = 1'b1;
    fill_set = IDX_W'(s);
    fill_way = WAY_W'(w);
    fill_tag = TAG_W'(t);
    fill_vld = v;
    @(posedge clk);
    #1 fill_en = 1'b0;
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, got hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (req_ready !== 1'b1 || rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: ready=%0b rsp_valid=%0b, expected 1 and 0", req_ready, rsp_valid);
    end

    // R1 R5: empty cache misses
    lookup(3, 'h0AA, 0, 0, 1, "R1");
    // R7 R2: fill moves guess, then fast hit
    fill(3, 5, 'h0AA, 1);
    lookup(3, 'h0AA, 1, 5, 0, "R7");
    // R4: guess moved to way 2 by fill, so way 5 needs the second step
    fill(3, 2, 'h155, 1);
    lookup(3, 'h0AA, 1, 5, 1, "R4");
    // R6: guess learned
    lookup(3, 'h0AA, 1, 5, 0, "R6");
    lookup(3, 'h155, 1, 2, 1, "R4");
    // R5 R3: tag mismatch misses
    lookup(3, 'h7FF, 0, 0, 1, "R5");
    lookup(3, 'h156, 0, 0, 1, "R3");
    // R8: misses kept guess at way 2
    lookup(3, 'h155, 1, 2, 0, "R8");
    // R9: another set is independent
    fill(7, 6, 'h0AA, 1);
    lookup(3, 'h155, 1, 2, 0, "R9");
    lookup(7, 'h0AA, 1, 6, 0, "R9");
    // R3: invalidated entry with equal tag misses
    fill(7, 6, 'h0AA, 0);
    lookup(7, 'h0AA, 0, 0, 1, "R3");
    drain();

    // R10: request offered during the busy cycle is ignored
    begin
      exp_t e;
      @(negedge clk);
      req_valid = 1'b1; req_set = 3; req_tag = 'h0AA;
      e.hit = 1; e.way = 5; e.slow = 1; e.acc = cyc; e.rq = "R10";
      exp_q.push_back(e);
      @(posedge clk);
      #1 req_tag = 'h155;
      @(posedge clk);
      #1 req_valid = 1'b0;
    end
    drain();
    lookup(3, 'h0AA, 1, 5, 0, "R10");
    // R11: back-to-back fast lookups
    lookup(3, 'h0AA, 1, 5, 0, "R11");
    lookup(3, 'h0AA, 1, 5, 0, "R11");
    // R4 R7: top way of top set
    fill(15, 7, 'hFFF, 1);
    lookup(15, 'hFFF, 1, 7, 0, "R7");
    fill(15, 0, 'h001, 1);
    lookup(15, 'hFFF, 1, 7, 1, "R4");
    lookup(15, 'h001, 1, 0, 1, "R4");
    drain();

    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R11: %0d responses missing, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule